// File: doc/BRIEF.md
# Stream CRC Inserter

This block keeps the running 16-bit checksum for a byte stream that passes through an addressable channel. Each access opens with a four-byte header: a command byte, two control bytes and an info byte. Data bytes follow, and they may be reads, writes or a mix of both. A two-bit field in the first control byte selects how often a checksum goes into the stream. The choices are never, after every data byte, after every 8 data bytes, or after every 32 data bytes.

When a block of data bytes is complete, the block raises an insert request toward the serializer. It presents the complemented checksum one byte at a time, low byte first, and holds off further data strobes until the serializer has taken both bytes. The first checksum of an access covers the header and the first block of data. Every later checksum covers only the data bytes of its own block. Each checksum starts from a cleared register.

Top module: `strm_crc_inserter`

## Requirements
- R1: After reset, ins_req is 0, byte_rdy is 1 and crc_out is 0000h.
- R2: byte_tag 01b marks a command byte and 10b marks a header byte; 00b and 11b mark data bytes. Bits [1:0] of the first header byte after a command select the mode: 00b none, 01b every data byte, 10b every 8 data bytes, 11b every 32 data bytes. The mode is chosen again in every access.
- R3: Data bytes are counted from the first data byte after the header. ins_req rises on the clock edge that accepts the last data byte of a block, and not before.
- R4: The first checksum of an access is computed from zero over the command byte, both control bytes, the info byte and the first block of data bytes.
- R5: Each later checksum of the same access is computed from zero over the data bytes of its own block only.
- R6: The checksum uses the polynomial x^16+x^15+x^2+1, with each byte shifted in least significant bit first. crc_out is the bitwise complement of the register. crc_byte shows crc_out[7:0] first and shows crc_out[15:8] after the first ins_ack.
- R7: ins_req and crc_out stay unchanged until the second ins_ack. ins_req is low from the edge that takes that second acknowledge.
- R8: byte_rdy is 0 while ins_req is 1. A strobe offered while byte_rdy is 0 has no effect on the count or on the checksum.
- R9: In mode none, ins_req never rises.
- R10: A command byte clears the block count and restarts the checksum, so a partial block from the previous access is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| byte_vld | input | 1 | Byte strobe |
| byte_tag | input | 2 | Byte kind: 01 command, 10 header, 00/11 data |
| byte_data | input | 8 | Byte value |
| byte_rdy | output | 1 | Block accepts a strobe this cycle |
| ins_ack | input | 1 | Serializer has taken the current checksum byte |
| ins_req | output | 1 | Checksum insertion pending |
| crc_out | output | 16 | Complemented checksum being inserted |
| crc_byte | output | 8 | Checksum byte to send now |

## Verification
One register lies between the accepting edge and the insertion outputs. ins_req, crc_out and the low crc_byte are therefore valid right after the edge that takes the closing data byte. The bench drives every input on the falling edge and reads the outputs on the next falling edge, so each result is sampled half a cycle after the edge that produces it. After the first acknowledge edge, the bench expects crc_byte to change to the high byte. After the second acknowledge edge, it expects ins_req to be low and byte_rdy to be high. Between these edges it samples on each waiting cycle to confirm that the outputs hold.

// File: rtl/sic_pkg.sv
package sic_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_EACH  = 2'b01,
    MODE_OCT   = 2'b10,
    MODE_LONG  = 2'b11
  } sic_mode_e;

  typedef enum logic [1:0] {
    IS_IDLE = 2'b00,
    IS_LO   = 2'b01,
    IS_HI   = 2'b10
  } sic_ins_st_e;

  localparam logic [1:0] TAG_CMD = 2'b01;
  localparam logic [1:0] TAG_HDR = 2'b10;
endpackage

// File: rtl/sic_crc_step.sv
module sic_crc_step #(
  parameter int          CRC_W = 16,
  parameter int          BYTE_W = 8,
  parameter logic [15:0] POLY_REFL = 16'hA001
) (
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [BYTE_W-1:0] data_in,
  output logic [CRC_W-1:0]  crc_nxt
);
  logic [BYTE_W:0][CRC_W-1:0] stage;

  assign stage[0] = crc_in;

  for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
    logic fb;
    assign fb = stage[i][0] ^ data_in[i];
    assign stage[i+1] = (stage[i] >> 1) ^ (fb ? POLY_REFL[CRC_W-1:0] : '0);
  end

  assign crc_nxt = stage[BYTE_W];
endmodule

// File: rtl/sic_block_ctr.sv
module sic_block_ctr
  import sic_pkg::*;
#(
  parameter int BLK_MID  = 8,
  parameter int BLK_LONG = 32,
  parameter int CNT_W    = $clog2(BLK_LONG) + 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      data_acc,
  input  sic_mode_e mode,
  output logic      blk_end
);
  localparam logic [CNT_W-1:0] LIM_EACH = CNT_W'(1);
  localparam logic [CNT_W-1:0] LIM_MID  = CNT_W'(BLK_MID);
  localparam logic [CNT_W-1:0] LIM_LONG = CNT_W'(BLK_LONG);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, limit;
  logic             cnt_en;

  always_comb begin
    case (mode)
      MODE_EACH: limit = LIM_EACH;
      MODE_OCT:  limit = LIM_MID;
      MODE_LONG: limit = LIM_LONG;
      default:   limit = '0;
    endcase
  end

  assign cnt_inc = cnt_q + 1'b1;
  assign blk_end = data_acc && (mode != MODE_OFF) && (cnt_inc == limit);

  always_comb begin
    cnt_en = clr || (data_acc && mode != MODE_OFF);
    if (clr || blk_end) cnt_d = '0;
    else                cnt_d = cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_OFF) |-> (cnt_q < limit));

  assert_off_count_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_OFF) |-> (cnt_q == '0));
endmodule

// File: rtl/sic_insert_fsm.sv
module sic_insert_fsm
  import sic_pkg::*;
#(
  parameter int CRC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CRC_W-1:0] crc_load,
  input  logic             ack,
  output logic             ins_req,
  output logic [CRC_W-1:0] crc_val,
  output logic [7:0]       crc_byte
);
  sic_ins_st_e      st_q, st_d;
  logic [CRC_W-1:0] val_q;
  logic             val_en;

  always_comb begin
    st_d = st_q;
    case (st_q)
      IS_IDLE: if (start) st_d = IS_LO;
      IS_LO:   if (ack)   st_d = IS_HI;
      IS_HI:   if (ack)   st_d = IS_IDLE;
      default: st_d = IS_IDLE;
    endcase
  end

  assign val_en = start && (st_q == IS_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= IS_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= '0;
    else if (val_en) val_q <= crc_load;
  end

  assign ins_req  = (st_q != IS_IDLE);
  assign crc_val  = val_q;
  assign crc_byte = (st_q == IS_HI) ? val_q[15:8] : val_q[7:0];

  assert_hold_until_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_req && !ack) |=> (ins_req && $stable(crc_val)));

  assert_release_after_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == IS_HI && ack) |=> !ins_req);

  assert_start_only_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (st_q == IS_IDLE));
endmodule

// File: rtl/strm_crc_inserter.sv
module strm_crc_inserter
  import sic_pkg::*;
#(
  parameter int          CRC_W     = 16,
  parameter logic [15:0] POLY_REFL = 16'hA001,
  parameter int          BLK_MID   = 8,
  parameter int          BLK_LONG  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic [1:0]       byte_tag,
  input  logic [7:0]       byte_data,
  output logic             byte_rdy,
  input  logic             ins_ack,
  output logic             ins_req,
  output logic [CRC_W-1:0] crc_out,
  output logic [7:0]       crc_byte
);
  localparam int HDR_W = 2;
  localparam logic [HDR_W-1:0] HIDX_CTRL1 = HDR_W'(1);
  localparam logic [HDR_W-1:0] HIDX_DONE  = HDR_W'(3);

  logic [1:0]       rs_q;
  logic             rst_i_n;
  logic             accept, is_cmd, is_hdr, is_data, blk_end;
  logic [CRC_W-1:0] crc_q, crc_d, step_in, step_out;
  sic_mode_e        mode_q, mode_d;
  logic [HDR_W-1:0] hidx_q, hidx_d;

  // reset: asserted at once, released on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  assign byte_rdy = !ins_req;
  assign accept   = byte_vld && byte_rdy;
  assign is_cmd   = (byte_tag == TAG_CMD);
  assign is_hdr   = (byte_tag == TAG_HDR);
  assign is_data  = !is_cmd && !is_hdr;

  assign step_in = is_cmd ? '0 : crc_q;

  sic_crc_step #(.CRC_W(CRC_W), .BYTE_W(8), .POLY_REFL(POLY_REFL)) u_step (
    .crc_in (step_in),
    .data_in(byte_data),
    .crc_nxt(step_out)
  );

  sic_block_ctr #(.BLK_MID(BLK_MID), .BLK_LONG(BLK_LONG)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .clr     (accept && is_cmd),
    .data_acc(accept && is_data),
    .mode    (mode_q),
    .blk_end (blk_end)
  );

  sic_insert_fsm #(.CRC_W(CRC_W)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .start   (blk_end),
    .crc_load(~step_out),
    .ack     (ins_ack),
    .ins_req (ins_req),
    .crc_val (crc_out),
    .crc_byte(crc_byte)
  );

  always_comb begin
    crc_d  = blk_end ? '0 : step_out;
    mode_d = mode_q;
    hidx_d = hidx_q;
    if (is_cmd) begin
      mode_d = MODE_OFF;
      hidx_d = HIDX_CTRL1;
    end else if (is_hdr) begin
      if (hidx_q == HIDX_CTRL1) mode_d = sic_mode_e'(byte_data[1:0]);
      if (hidx_q != HIDX_DONE)  hidx_d = hidx_q + 1'b1;
    end else begin
      hidx_d = HIDX_DONE;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      crc_q  <= '0;
      mode_q <= MODE_OFF;
      hidx_q <= HIDX_DONE;
    end else if (accept) begin
      crc_q  <= crc_d;
      mode_q <= mode_d;
      hidx_q <= hidx_d;
    end
  end

  assert_rise_after_data_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(ins_req) |-> $past(accept && is_data));

  assert_off_never_inserts_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (accept && mode_q == MODE_OFF) |=> !$rose(ins_req));

  assert_cmd_restarts_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    (accept && is_cmd) |=> !$rose(ins_req));
endmodule

// File: tb/tb_strm_crc_inserter.sv
`timescale 1ns/100ps
module tb_strm_crc_inserter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        byte_vld, ins_ack;
  logic [1:0]  byte_tag;
  logic [7:0]  byte_data;
  logic        byte_rdy, ins_req;
  logic [15:0] crc_out;
  logic [7:0]  crc_byte;

  int checks = 0;
  int fails  = 0;

  logic [15:0] m_crc;
  logic [1:0]  m_mode;
  int          m_cnt;
  bit          m_first;
  bit          m_probe;
  string       m_first_tag;

  always #2.5 clk = ~clk;

  strm_crc_inserter dut (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_tag(byte_tag),
    .byte_data(byte_data), .byte_rdy(byte_rdy), .ins_ack(ins_ack),
    .ins_req(ins_req), .crc_out(crc_out), .crc_byte(crc_byte)
  );

  function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 16'hA001;
      else             r = r >> 1;
    end
    return r;
  endfunction

  function automatic int blk_len(input logic [1:0] m);
    case (m)
      2'b01:   return 1;
      2'b10:   return 8;
      2'b11:   return 32;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic service(input logic [15:0] exp, input string tag);
    int w;
    chk(tag, {16'h0, crc_out}, {16'h0, exp});
    chk("R2 R3 ins_req raised", {31'h0, ins_req}, 1);
    chk("R8 byte_rdy low", {31'h0, byte_rdy}, 0);
    chk("R6 low byte first", {24'h0, crc_byte}, {24'h0, exp[7:0]});
    w = m_probe ? 2 : int'($urandom_range(0, 2));
    if (m_probe) begin
      byte_vld = 1'b1; byte_tag = 2'b00; byte_data = 8'h5A;
    end
    for (int k = 0; k < w; k++) begin
      @(negedge clk);
      chk("R7 held", {15'h0, ins_req, crc_out}, {15'h0, 1'b1, exp});
    end
    byte_vld = 1'b0;
    @(negedge clk) ins_ack = 1'b1;
    @(negedge clk) ins_ack = 1'b0;
    chk("R6 high byte", {24'h0, crc_byte}, {24'h0, exp[15:8]});
    chk("R7 still pending", {31'h0, ins_req}, 1);
    @(negedge clk) ins_ack = 1'b1;
    @(negedge clk) ins_ack = 1'b0;
    chk("R7 released", {31'h0, ins_req}, 0);
    chk("R8 ready again", {31'h0, byte_rdy}, 1);
  endtask

  task automatic put(input logic [1:0] tag, input logic [7:0] d);
    logic [15:0] nc;
    @(negedge clk);
    byte_vld = 1'b1; byte_tag = tag; byte_data = d;
    @(negedge clk);
    byte_vld = 1'b0;
    if (tag == 2'b01) begin
      m_crc = crc_upd(16'h0, d); m_cnt = 0; m_mode = 2'b00; m_first = 1'b1;
    end else if (tag == 2'b10) begin
      m_crc = crc_upd(m_crc, d);
    end else begin
      nc = crc_upd(m_crc, d);
      if (m_mode != 2'b00) begin
        m_cnt++;
        if (m_cnt == blk_len(m_mode)) begin
          m_crc = 16'h0; m_cnt = 0;
          service(~nc, m_first ? m_first_tag : "R5 later block crc");
          m_first = 1'b0;
        end else begin
          m_crc = nc;
          chk("R3 no early insert", {31'h0, ins_req}, 0);
        end
      end else begin
        m_crc = nc;
        chk("R9 mode none", {31'h0, ins_req}, 0);
      end
    end
  endtask

  task automatic access(input logic [1:0] mode, input int n, input bit rnd);
    logic [7:0] c1;
    c1 = {8'($urandom_range(0, 63)), mode};
    put(2'b01, rnd ? 8'($urandom) : 8'hF5);
    put(2'b10, c1);
    m_mode = mode;
    put(2'b10, rnd ? 8'($urandom) : 8'h0C);
    put(2'b10, rnd ? 8'($urandom) : 8'h33);
    for (int i = 0; i < n; i++)
      put(($urandom_range(0, 1) == 0) ? 2'b00 : 2'b11, 8'($urandom));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    byte_vld = 1'b0; ins_ack = 1'b0; byte_tag = 2'b00; byte_data = 8'h00;
    m_crc = 16'h0; m_mode = 2'b00; m_cnt = 0; m_first = 1'b0; m_probe = 1'b0;
    m_first_tag = "R4 first block crc";
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 ins_req reset", {31'h0, ins_req}, 0);
    chk("R1 byte_rdy reset", {31'h0, byte_rdy}, 1);
    chk("R1 crc_out reset", {16'h0, crc_out}, 0);

    // R2 mode relatched on each access, R4 and R5 coverage
    access(2'b01, 3, 1'b0);
    access(2'b10, 20, 1'b0);
    access(2'b11, 70, 1'b0);
    access(2'b00, 40, 1'b0);
    access(2'b10, 9, 1'b1);

    // R8: strobe offered while stalled must be ignored
    m_probe = 1'b1;
    access(2'b01, 4, 1'b1);
    m_probe = 1'b0;

    // R10: partial block dropped by a new command
    access(2'b10, 5, 1'b1);
    m_first_tag = "R10 restart after partial block";
    access(2'b10, 8, 1'b1);
    m_first_tag = "R4 first block crc";

    for (int a = 0; a < 25; a++)
      access(2'($urandom_range(0, 3)), int'($urandom_range(0, 80)), 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule